// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core runs one instruction per clock from a word-addressed program store. Each cycle it fetches the word at the program counter, decodes it, reads two registers, and commits its result on the next rising edge. A result can go to the register file, the data store, the display register or the program counter. The register file has 32 entries of 32 bits. The data store holds 2048 words. The program counter is 11 bits wide.

The program store has no write port. It is filled by hierarchical assignment while reset is held, and it starts out zero-filled. The core talks to the outside through an 11-bit switch input, a 32-bit display register and a sign LED. There is no stall, no pipeline and no interrupt.

Every instruction word has the same layout:

- opcode in bits 31:26;
- register fields A in 25:21, B in 20:16 and C in 15:11;
- a short immediate in 10:0, or a long immediate in 20:0.

Top module: `cpu_core`

## Requirements
- R1: While rst_ni is low, disp_o and led_o are 0 and the program counter is 0. Execution starts at address 0 after release.
- R2: Opcodes 0 (add), 1 (subtract) and 2 (multiply) write field A with field-B register op field-C register, truncated to 32 bits.
- R3: Opcode 3 (divide) and opcode 4 (remainder) are unsigned. When the divisor is 0, divide gives 0xFFFFFFFF and remainder gives the dividend.
- R4: Opcode 5 (left shift) and opcode 6 (logical right shift) shift register B by the full 32-bit value of register C. A shift of 32 or more gives 0.
- R5: Opcode 7 (logical and), opcode 8 (logical or) and opcode 9 (logical not of register B) write 1 or 0 to register A.
- R6: Opcodes 10 (equal), 11 (not equal), 12 (signed less) and 13 (signed less-or-equal) compare register B with register C and write 1 or 0 to register A.
- R7: Opcode 14 copies register C into register B.
- R8: Opcode 17 writes bits 20:0, zero-extended, into register A. Opcode 18 writes sw_i, zero-extended, into register A.
- R9: Opcode 16 stores register B, and opcode 15 loads into register A. Both use the address (register C + bits 10:0) modulo 2048.
- R10: Opcode 19 loads disp_o with register B and led_o with bit 31 of register B, one edge later. No other instruction changes either output.
- R11: Opcode 20 jumps to the low 11 bits of register B. Opcode 21 jumps there when register C is 0, and otherwise falls through. All other instructions advance the counter by 1.
- R12: Opcode 22 holds the counter, and nothing further executes. Opcodes 23 to 63 change no state except advancing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | 11 | Switch value sampled by opcode 18 |
| disp_o | output | 32 | Display register |
| led_o | output | 1 | Sign LED |

## Verification
The assertions assume that the program store is only written while reset is held, so the fetched word is stable and defined during execution. They also assume that sw_i changes only between instructions. The bench writes each program with rst_ni low and releases reset at a falling edge. It drives the switches before release and keeps them still during the run. Every program ends in a halt, and the store beyond each program is filled with halts, so no run can fetch a stale word.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int OP_W = 6;
  localparam int RA_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 6'd0,  OP_SUB = 6'd1,  OP_MUL = 6'd2,  OP_DIV = 6'd3,
    OP_REM = 6'd4,  OP_SHL = 6'd5,  OP_SHR = 6'd6,  OP_LAND = 6'd7,
    OP_LOR = 6'd8,  OP_LNOT = 6'd9, OP_EQ = 6'd10,  OP_NE = 6'd11,
    OP_LT = 6'd12,  OP_LE = 6'd13,  OP_MOV = 6'd14, OP_LD = 6'd15,
    OP_ST = 6'd16,  OP_IMM = 6'd17, OP_IN = 6'd18,  OP_OUT = 6'd19,
    OP_JMP = 6'd20, OP_BZ = 6'd21,  OP_HALT = 6'd22, OP_NOP = 6'd23
  } op_e;
endpackage

// File: rtl/cpu_imem.sv
module cpu_imem #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  // Filled by the environment while reset is held; zero at start.
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int NRD = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NRD*AW-1:0]   raddr_i,
  output logic [NRD*DW-1:0]   rdata_o,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [DW-1:0]       wdata_i
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g*DW +: DW] = regs_q[raddr_i[g*AW +: AW]];
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   y_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic b_zero, a_zero, big_sh;
  assign a_zero = (a_i == '0);
  assign b_zero = (b_i == '0);
  assign big_sh = (b_i >= DW'(DW));

  always_comb begin
    y_o = '0;
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = a_i * b_i;
      OP_DIV:  y_o = b_zero ? '1 : a_i / b_i;
      OP_REM:  y_o = b_zero ? a_i : a_i % b_i;
      OP_SHL:  y_o = big_sh ? '0 : a_i << b_i;
      OP_SHR:  y_o = big_sh ? '0 : a_i >> b_i;
      OP_LAND: y_o = (!a_zero && !b_zero) ? ONE : '0;
      OP_LOR:  y_o = (!a_zero || !b_zero) ? ONE : '0;
      OP_LNOT: y_o = a_zero ? ONE : '0;
      OP_EQ:   y_o = (a_i == b_i) ? ONE : '0;
      OP_NE:   y_o = (a_i != b_i) ? ONE : '0;
      OP_LT:   y_o = ($signed(a_i) <  $signed(b_i)) ? ONE : '0;
      OP_LE:   y_o = ($signed(a_i) <= $signed(b_i)) ? ONE : '0;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_dmem.sv
module cpu_dmem #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  // R9: a stored word is readable at its address on the next cycle
  p_store_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 11,
  parameter int DM_AW = 11,
  parameter int SW_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW_W-1:0] sw_i,
  output logic [XLEN-1:0] disp_o,
  output logic            led_o
);
  localparam int IM_S = 11;
  localparam int IM_L = 21;

  logic [PC_W-1:0] pc_q, pc_d, pc_inc;
  logic [31:0]     instr;
  logic [OP_W-1:0] op;
  logic [RA_W-1:0] fa, fb, fc;
  logic [IM_S-1:0] imm_s;
  logic [IM_L-1:0] imm_l;

  cpu_imem #(.AW(PC_W), .DW(32)) u_imem (.addr_i(pc_q), .data_o(instr));

  assign op    = instr[31:26];
  assign fa    = instr[25:21];
  assign fb    = instr[20:16];
  assign fc    = instr[15:11];
  assign imm_s = instr[10:0];
  assign imm_l = instr[20:0];

  logic [2*XLEN-1:0] rd_bus;
  logic [XLEN-1:0]   rv_b, rv_c, alu_y, dm_rdata;
  logic              rf_we;
  logic [RA_W-1:0]   rf_wa;
  logic [XLEN-1:0]   rf_wd;
  logic [DM_AW-1:0]  dm_addr;
  logic              dm_we;

  cpu_regfile #(.AW(RA_W), .DW(XLEN), .NRD(2)) u_rf (
    .clk_i, .rst_ni,
    .raddr_i({fc, fb}), .rdata_o(rd_bus),
    .we_i(rf_we), .waddr_i(rf_wa), .wdata_i(rf_wd)
  );
  assign rv_b = rd_bus[XLEN-1:0];
  assign rv_c = rd_bus[2*XLEN-1:XLEN];

  cpu_alu #(.DW(XLEN)) u_alu (.op_i(op), .a_i(rv_b), .b_i(rv_c), .y_o(alu_y));

  // Indexed address wraps within the data store
  assign dm_addr = rv_c[DM_AW-1:0] + DM_AW'(imm_s);
  assign dm_we   = (op == OP_ST);

  cpu_dmem #(.AW(DM_AW), .DW(XLEN)) u_dm (
    .clk_i, .rst_ni, .we_i(dm_we), .addr_i(dm_addr),
    .wdata_i(rv_b), .rdata_o(dm_rdata)
  );

  always_comb begin
    rf_we = 1'b0;
    rf_wa = fa;
    rf_wd = alu_y;
    if (op <= OP_LE) rf_we = 1'b1;
    case (op)
      OP_MOV: begin rf_we = 1'b1; rf_wa = fb; rf_wd = rv_c; end
      OP_LD:  begin rf_we = 1'b1; rf_wd = dm_rdata; end
      OP_IMM: begin rf_we = 1'b1; rf_wd = XLEN'(imm_l); end
      OP_IN:  begin rf_we = 1'b1; rf_wd = XLEN'(sw_i); end
      default: ;
    endcase
  end

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    case (op)
      OP_JMP:  pc_d = rv_b[PC_W-1:0];
      OP_BZ:   pc_d = (rv_c == '0) ? rv_b[PC_W-1:0] : pc_inc;
      OP_HALT: pc_d = pc_q;
      default: pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      disp_o <= '0;
      led_o  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (op == OP_OUT) begin
        disp_o <= rv_b;
        led_o  <= rv_b[XLEN-1];
      end
    end
  end

  logic seq_op;
  assign seq_op = (op != OP_JMP) && (op != OP_BZ) && (op != OP_HALT);

  p_pc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_op |=> (pc_q == $past(pc_q) + PC_W'(1)));

  p_halt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_HALT) |=> ($stable(pc_q) && (op == OP_HALT)));

  p_halt_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_HALT) |-> (!rf_we && !dm_we));

  p_undef_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op > OP_NOP) |-> (!rf_we && !dm_we));

  p_disp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_OUT) |=> ($stable(disp_o) && $stable(led_o)));

  p_led_sign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_OUT) |=> (led_o == disp_o[XLEN-1]));

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (disp_o == '0 && !led_o && pc_q == '0));
endmodule

// File: tb/cpu_core_test.sv
`timescale 1ns/1ps
module cpu_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] sw_i = '0;
  logic [31:0] disp_o;
  logic        led_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cpu_core uut (.clk_i, .rst_ni, .sw_i, .disp_o, .led_o);

  logic [31:0] prog [64];
  int plen;

  function automatic logic [31:0] enc(int op, int a, int b, int c, int im);
    return {op[5:0], a[4:0], b[4:0], c[4:0], im[10:0]};
  endfunction

  function automatic logic [31:0] enc_l(int op, int a, logic [20:0] im);
    return {op[5:0], a[4:0], im};
  endfunction

  function automatic logic [31:0] alu_ref(int op, logic [31:0] x, logic [31:0] y);
    case (op)
      0: return x + y;
      1: return x - y;
      2: return x * y;
      3: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      4: return (y == 0) ? x : x % y;
      5: return (y > 31) ? 32'd0 : x << y[4:0];
      6: return (y > 31) ? 32'd0 : x >> y[4:0];
      7: return {31'd0, (x != 0) && (y != 0)};
      8: return {31'd0, (x != 0) || (y != 0)};
      9: return {31'd0, x == 0};
      10: return {31'd0, x == y};
      11: return {31'd0, x != y};
      12: return {31'd0, $signed(x) < $signed(y)};
      default: return {31'd0, $signed(x) <= $signed(y)};
    endcase
  endfunction

  function automatic string tag_of(int op);
    if (op <= 2) return "R2";
    if (op <= 4) return "R3";
    if (op <= 6) return "R4";
    if (op <= 9) return "R5";
    return "R6";
  endfunction

  task automatic begin_prog();
    plen = 0;
  endtask

  task automatic emit(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // Full 32-bit constant through shift and add; clobbers r30, r31
  task automatic ldc(int r, logic [31:0] v);
    emit(enc_l(17, r, {10'd0, v[31:21]}));
    emit(enc_l(17, 31, 21'd21));
    emit(enc(5, r, r, 31, 0));
    emit(enc_l(17, 30, v[20:0]));
    emit(enc(0, r, r, 30, 0));
  endtask

  task automatic run(int extra);
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < plen; i++) uut.u_imem.mem[i] = prog[i];
    for (int i = plen; i < plen + 8; i++) uut.u_imem.mem[i] = enc(22, 0, 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (plen + extra + 4) @(negedge clk_i);
  endtask

  task automatic check(string tag, logic [31:0] exp);
    n_chk++;
    if (disp_o !== exp || led_o !== exp[31]) begin
      n_fail++;
      $display("FAIL %s: disp=%h led=%b expected disp=%h led=%b", tag, disp_o, led_o, exp, exp[31]);
    end
  endtask

  task automatic alu_case(int op, logic [31:0] x, logic [31:0] y);
    int rb, rc, ra;
    rb = $urandom_range(1, 14);
    rc = $urandom_range(15, 29);
    ra = $urandom_range(1, 29);
    begin_prog();
    ldc(rb, x);
    ldc(rc, y);
    emit(enc(op, ra, rb, rc, $urandom_range(0, 2047)));
    emit(enc(19, 0, ra, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check(tag_of(op), alu_ref(op, x, y));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 4))
      0: return $urandom();
      1: return $urandom_range(0, 40);
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4057));

    // R1: outputs clear under reset after a run that set them
    begin_prog();
    ldc(3, 32'hDEAD_BEEF);
    emit(enc(19, 0, 3, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R10", 32'hDEAD_BEEF);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1", 32'd0);

    // Directed ALU corners
    alu_case(3, 32'd77, 32'd0);
    alu_case(4, 32'd77, 32'd0);
    alu_case(3, 32'hFFFF_FFFE, 32'd3);
    alu_case(5, 32'd1, 32'd32);
    alu_case(5, 32'd1, 32'd31);
    alu_case(6, 32'h8000_0000, 32'd31);
    alu_case(6, 32'hFFFF_FFFF, 32'h1_0000);
    alu_case(12, 32'hFFFF_FFFF, 32'd1);
    alu_case(13, 32'd5, 32'd5);
    alu_case(9, 32'd0, 32'd9);
    alu_case(2, 32'h1234_5678, 32'h9ABC_DEF0);

    // Random ALU mix
    for (int k = 0; k < 70; k++) alu_case($urandom_range(0, 13), pick(), pick());

    // R7: copy register C into register B
    begin_prog();
    ldc(9, 32'hC001_0042);
    emit(enc(14, 5, 12, 9, 0));
    emit(enc(19, 0, 12, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R7", 32'hC001_0042);

    // R8: long immediate zero-extended
    begin_prog();
    emit(enc_l(17, 5, 21'h1F_FFFF));
    emit(enc(19, 0, 5, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R8", 32'h001F_FFFF);

    // R8: switch capture zero-extended
    for (int k = 0; k < 3; k++) begin
      logic [10:0] s;
      s = (k == 0) ? 11'h7FF : 11'($urandom());
      sw_i = s;
      begin_prog();
      emit(enc(18, 6, 0, 0, 0));
      emit(enc(19, 0, 6, 0, 0));
      emit(enc(22, 0, 0, 0, 0));
      run(0);
      check("R8", {21'd0, s});
    end

    // R9: store at 2040+20 wraps to 12, load back from r0(=0)+12
    begin_prog();
    ldc(4, 32'd2040);
    ldc(7, 32'hA5A5_0F0F);
    emit(enc(16, 0, 7, 4, 20));
    emit(enc(15, 8, 0, 0, 12));
    emit(enc(19, 0, 8, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R9", 32'hA5A5_0F0F);

    // R9: random base and offset
    for (int k = 0; k < 4; k++) begin
      logic [31:0] base, dat;
      int off;
      base = $urandom();
      dat = $urandom();
      off = $urandom_range(0, 2047);
      begin_prog();
      ldc(4, base);
      ldc(7, dat);
      emit(enc(16, 0, 7, 4, off));
      ldc(10, 32'(base[10:0] + 11'(off)));
      emit(enc(15, 8, 0, 10, 0));
      emit(enc(19, 0, 8, 0, 0));
      emit(enc(22, 0, 0, 0, 0));
      run(0);
      check("R9", dat);
    end

    // R10: display holds after the source register changes
    begin_prog();
    ldc(1, 32'h8000_0007);
    emit(enc(19, 0, 1, 0, 0));
    emit(enc_l(17, 1, 21'd3));
    emit(enc(0, 2, 1, 1, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R10", 32'h8000_0007);

    // R11: jump uses low 11 bits of register B, skipping a poison OUT
    begin_prog();
    emit(enc_l(17, 1, 21'h800 | 21'd6));
    emit(enc(20, 0, 1, 0, 0));
    emit(enc_l(17, 2, 21'hBAD));
    emit(enc(19, 0, 2, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    emit(enc_l(17, 2, 21'h123));
    emit(enc(19, 0, 2, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R11", 32'h123);

    // R11: branch-if-zero taken (r3=0) and not taken (r4=1)
    begin_prog();
    emit(enc_l(17, 1, 21'd5));
    emit(enc(21, 0, 1, 3, 0));
    emit(enc_l(17, 2, 21'hBAD));
    emit(enc(19, 0, 2, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    emit(enc_l(17, 4, 21'd1));
    emit(enc(21, 0, 1, 4, 0));
    emit(enc_l(17, 2, 21'h77));
    emit(enc(19, 0, 2, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    run(0);
    check("R11", 32'h77);

    // R12: halt stops execution; undefined opcodes only advance
    begin_prog();
    emit(enc_l(17, 1, 21'd7));
    emit(enc(40, 1, 1, 1, 0));
    emit(enc(63, 1, 0, 1, 5));
    emit(enc(23, 1, 1, 1, 0));
    emit(enc(19, 0, 1, 0, 0));
    emit(enc(22, 0, 0, 0, 0));
    emit(enc_l(17, 1, 21'd9));
    emit(enc(19, 0, 1, 0, 0));
    run(20);
    check("R12", 32'd7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule